// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and drives two active-high request lines toward a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has its own enable mask over the same sources, so a source can be routed to either line, to both, or to neither. A software-interrupt register lets firmware raise any source by itself. This is useful for testing handlers and for signalling between threads.

Software reaches the block over a plain 32-bit register bus. Enables and soft interrupts are never written directly. Firmware writes a word to a set address or to a clear address, and only the bits written as 1 change. Firmware reads a masked status word and services its set bits, lowest bit first. The raw and masked status words of both lines can be read back, and so can the fast-line enable mask.

When `PASS_EN` is 1, a pass-through mask selects sources whose raw state is also driven out on `pass_o`. This lets an upstream controller see those sources directly when controllers are cascaded. A typical setting is 0xFFD00000, which forwards sources 20 and 22 to 31. When `PASS_EN` is 0, `pass_o` is tied to zero.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, every enable, soft and pass-through bit is 0. Both request lines are low, and every readable address returns 0 while all sources are low.
- R2: A write to 0x08 sets the normal-line enable of each source whose data bit is 1. Bits written as 0 keep their old value.
- R3: A write to 0x0C clears the normal-line enable of each source whose data bit is 1. Bits written as 0 keep their old value.
- R4: A write to 0x10 sets soft bits and a write to 0x14 clears soft bits, in both cases for the bits written as 1. Raw status, read at 0x04 and at 0x24, is the external source input ORed with the soft register.
- R5: Normal masked status, read at 0x00, is raw status ANDed with the normal-line enable mask. It follows the source level with no latching.
- R6: `irq_o` is high exactly one clock after any bit of the normal masked status is high. It falls in the clock after the last bit drops, so a status read issued in a cycle returns nonzero exactly when `irq_o` is high in the following cycle.
- R7: The fast line behaves independently of the normal line. Masked status is at 0x20, raw status at 0x24, enable-set at 0x28 and enable-clear at 0x2C. A read of 0x28 returns the fast enable mask. `fiq_o` follows the fast masked status one clock later.
- R8: The pass-through mask at 0x30 is written directly and reads back. `pass_o` is raw status ANDed with this mask, with no register in the path.
- R9: Writes to the status addresses 0x00, 0x04, 0x20 and 0x24 change nothing. Reads of 0x08, 0x0C, 0x10, 0x14, 0x2C and of any unmapped address return 0.
- R10: `rd_data` carries the value of the address presented with `rd_en` in the clock after that read. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Level interrupt sources, high = requesting |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | 32 | Read data, valid in the cycle after `rd_en` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| pass_o | output | 32 | Sources forwarded to an upstream controller |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that the bus inputs hold known values from the first clock edge on. The set and clear checks further rely on exactly one write reaching the block per cycle. The bench drives every bus input to 0 at time zero. It then issues each access as a single-cycle strobe followed by an idle cycle, so reads and writes never overlap and the idle-cycle behaviour of `rd_data` is exercised throughout. Source inputs change only on falling clock edges.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_IRQ_MSK  = 8'h00;
    localparam logic [ADDR_W-1:0] A_IRQ_RAW  = 8'h04;
    localparam logic [ADDR_W-1:0] A_IRQ_SET  = 8'h08;
    localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_SOFT_SET = 8'h10;
    localparam logic [ADDR_W-1:0] A_SOFT_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] A_FIQ_MSK  = 8'h20;
    localparam logic [ADDR_W-1:0] A_FIQ_RAW  = 8'h24;
    localparam logic [ADDR_W-1:0] A_FIQ_SET  = 8'h28;
    localparam logic [ADDR_W-1:0] A_FIQ_CLR  = 8'h2C;
    localparam logic [ADDR_W-1:0] A_PASS     = 8'h30;

    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // clear wins when both strobes hit the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o | set_i) & ~clr_i;
    end
endmodule

// File: rtl/intc_reqline.sv
module intc_reqline #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec_i,
    output logic         req_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= |vec_i;
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import intc_pkg::*;
#(
    parameter bit PASS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [DATA_W-1:0] pass_o
);
    word_t irq_en, fiq_en, soft_q, pass_q;
    word_t raw_stat, irq_mstat, fiq_mstat;
    word_t rd_mux;

    function automatic word_t strobe(input logic [ADDR_W-1:0] a);
        return (wr_en && addr == a) ? wr_data : '0;
    endfunction

    intc_setclr_reg #(.W(DATA_W)) u_irq_en (
        .clk(clk), .rst_n(rst_n),
        .set_i(strobe(A_IRQ_SET)), .clr_i(strobe(A_IRQ_CLR)), .q_o(irq_en));

    intc_setclr_reg #(.W(DATA_W)) u_fiq_en (
        .clk(clk), .rst_n(rst_n),
        .set_i(strobe(A_FIQ_SET)), .clr_i(strobe(A_FIQ_CLR)), .q_o(fiq_en));

    intc_setclr_reg #(.W(DATA_W)) u_soft (
        .clk(clk), .rst_n(rst_n),
        .set_i(strobe(A_SOFT_SET)), .clr_i(strobe(A_SOFT_CLR)), .q_o(soft_q));

    generate
        if (PASS_EN) begin : g_pass
            always_ff @(posedge clk) begin
                if (!rst_n)                       pass_q <= '0;
                else if (wr_en && addr == A_PASS) pass_q <= wr_data;
            end
        end else begin : g_nopass
            assign pass_q = '0;
        end
    endgenerate

    assign raw_stat  = src_in | soft_q;
    assign irq_mstat = raw_stat & irq_en;
    assign fiq_mstat = raw_stat & fiq_en;
    assign pass_o    = raw_stat & pass_q;

    intc_reqline #(.W(DATA_W)) u_irq_line (
        .clk(clk), .rst_n(rst_n), .vec_i(irq_mstat), .req_o(irq_o));

    intc_reqline #(.W(DATA_W)) u_fiq_line (
        .clk(clk), .rst_n(rst_n), .vec_i(fiq_mstat), .req_o(fiq_o));

    always_comb begin
        unique case (addr)
            A_IRQ_MSK: rd_mux = irq_mstat;
            A_IRQ_RAW: rd_mux = raw_stat;
            A_FIQ_MSK: rd_mux = fiq_mstat;
            A_FIQ_RAW: rd_mux = raw_stat;
            A_FIQ_SET: rd_mux = fiq_en;
            A_PASS:    rd_mux = pass_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
        else            rd_data <= '0;
    end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [DATA_W-1:0] pass_o,
    input logic [DATA_W-1:0] raw_stat,
    input logic [DATA_W-1:0] irq_en
);
    // R1: lines are low in the first cycle after reset
    a_r1_lines_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_o && !fiq_o));

    // R2: every bit written to the set address is enabled afterwards
    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == A_IRQ_SET) |-> ((irq_en & $past(wr_data)) == $past(wr_data)));

    // R3: every bit written to the clear address is disabled afterwards
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == A_IRQ_CLR) |-> ((irq_en & $past(wr_data)) == '0));

    // R6: a masked-status read is nonzero exactly when the request line is high
    a_r6_read_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr == A_IRQ_MSK) |-> ((rd_data != '0) == irq_o));

    // R7: same relation on the fast line
    a_r7_read_matches_fiq: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && addr == A_FIQ_MSK) |-> ((rd_data != '0) == fiq_o));

    // R8: forwarded bits are always a subset of raw status
    a_r8_pass_in_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o & ~raw_stat) == '0);

    // R9: write-only addresses read as zero
    a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (addr == A_IRQ_SET || addr == A_IRQ_CLR || addr == A_SOFT_SET ||
                        addr == A_SOFT_CLR || addr == A_FIQ_CLR)) |-> (rd_data == '0));

    // R10: no read issued, no data
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rd_data == '0));
endmodule

bind dual_irq_ctrl intc_checker u_intc_checker (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o), .fiq_o(fiq_o),
    .pass_o(pass_o), .raw_stat(raw_stat), .irq_en(irq_en));

// File: tb/test_dual_irq_ctrl.sv
`timescale 1ns/1ps
module test_dual_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq_o, fiq_o;
    logic [31:0] pass_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_irq_ctrl i_dual_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o),
        .fiq_o(fiq_o), .pass_o(pass_o));

    typedef struct packed {
        logic [3:0]  rq;
        logic        rd;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] s;
        logic [31:0] e;
        logic        ei;
        logic        ef;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  1'b1, 8'h00, 32'h0,          32'h0,          32'h0,          1'b0, 1'b0}, // R1
        '{4'd1,  1'b1, 8'h28, 32'h0,          32'h0,          32'h0,          1'b0, 1'b0}, // R1
        '{4'd2,  1'b0, 8'h08, 32'h0000_00F0,  32'h0,          32'h0,          1'b0, 1'b0}, // R2
        '{4'd4,  1'b1, 8'h04, 32'h0,          32'h0000_0033,  32'h0000_0033,  1'b1, 1'b0}, // R4
        '{4'd5,  1'b1, 8'h00, 32'h0,          32'h0000_0033,  32'h0000_0030,  1'b1, 1'b0}, // R5
        '{4'd3,  1'b0, 8'h0C, 32'h0000_0010,  32'h0000_0033,  32'h0,          1'b0, 1'b0}, // R3
        '{4'd3,  1'b1, 8'h00, 32'h0,          32'h0000_0033,  32'h0000_0020,  1'b1, 1'b0}, // R3
        '{4'd6,  1'b1, 8'h00, 32'h0,          32'h0000_0003,  32'h0,          1'b0, 1'b0}, // R6
        '{4'd4,  1'b0, 8'h10, 32'h8000_0000,  32'h0,          32'h0,          1'b0, 1'b0}, // R4
        '{4'd4,  1'b1, 8'h04, 32'h0,          32'h0000_0001,  32'h8000_0001,  1'b0, 1'b0}, // R4
        '{4'd2,  1'b0, 8'h08, 32'h8000_0000,  32'h0,          32'h0,          1'b0, 1'b0}, // R2
        '{4'd2,  1'b1, 8'h00, 32'h0,          32'h0,          32'h8000_0000,  1'b1, 1'b0}, // R2
        '{4'd4,  1'b0, 8'h14, 32'h8000_0000,  32'h0,          32'h0,          1'b0, 1'b0}, // R4
        '{4'd4,  1'b1, 8'h04, 32'h0,          32'h0,          32'h0,          1'b0, 1'b0}, // R4
        '{4'd7,  1'b0, 8'h28, 32'h0000_0101,  32'h0,          32'h0,          1'b0, 1'b0}, // R7
        '{4'd7,  1'b1, 8'h28, 32'h0,          32'h0,          32'h0000_0101,  1'b0, 1'b0}, // R7
        '{4'd7,  1'b1, 8'h20, 32'h0,          32'h0000_0100,  32'h0000_0100,  1'b0, 1'b1}, // R7
        '{4'd7,  1'b1, 8'h24, 32'h0,          32'h0000_0100,  32'h0000_0100,  1'b0, 1'b1}, // R7
        '{4'd7,  1'b0, 8'h2C, 32'h0000_0100,  32'h0000_0100,  32'h0,          1'b0, 1'b0}, // R7
        '{4'd7,  1'b1, 8'h28, 32'h0,          32'h0000_0100,  32'h0000_0001,  1'b0, 1'b0}, // R7
        '{4'd9,  1'b0, 8'h00, 32'hFFFF_FFFF,  32'h0,          32'h0,          1'b0, 1'b0}, // R9
        '{4'd9,  1'b0, 8'h04, 32'hFFFF_FFFF,  32'h0,          32'h0,          1'b0, 1'b0}, // R9
        '{4'd9,  1'b1, 8'h04, 32'h0,          32'h0,          32'h0,          1'b0, 1'b0}, // R9
        '{4'd9,  1'b1, 8'h08, 32'h0,          32'h0,          32'h0,          1'b0, 1'b0}, // R9
        '{4'd9,  1'b1, 8'h14, 32'h0,          32'h0,          32'h0,          1'b0, 1'b0}, // R9
        '{4'd8,  1'b0, 8'h30, 32'hFFD0_0000,  32'h0,          32'h0,          1'b0, 1'b0}, // R8
        '{4'd8,  1'b1, 8'h30, 32'h0,          32'h0,          32'hFFD0_0000,  1'b0, 1'b0}, // R8
        '{4'd9,  1'b1, 8'h3C, 32'h0,          32'h0,          32'h0,          1'b0, 1'b0}, // R9
        '{4'd5,  1'b1, 8'h00, 32'h0,          32'h0000_0020,  32'h0000_0020,  1'b1, 1'b0}  // R5
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 fiq", {31'b0, fiq_o}, 32'h0);
        chk("R1 pass", pass_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            src_in = VEC[i].s; addr = VEC[i].a;
            if (VEC[i].rd) rd_en = 1'b1;
            else begin wr_en = 1'b1; wr_data = VEC[i].d; end
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
            if (VEC[i].rd) begin
                chk($sformatf("R%0d vec%0d data", VEC[i].rq, i), rd_data, VEC[i].e);
                chk($sformatf("R%0d vec%0d irq", VEC[i].rq, i), {31'b0, irq_o}, {31'b0, VEC[i].ei});
                chk($sformatf("R%0d vec%0d fiq", VEC[i].rq, i), {31'b0, fiq_o}, {31'b0, VEC[i].ef});
            end
        end

        // R10: idle cycle after a read yields zero data
        @(negedge clk);
        chk("R10 idle", rd_data, 32'h0);

        // R8: combinational forward path, source plus soft bit
        src_in = 32'h0030_0001;
        #1 chk("R8 pass src", pass_o, 32'h0010_0000);
        bus_wr(8'h10, 32'h0040_0000);
        src_in = 32'h0;
        #1 chk("R8 pass soft", pass_o, 32'h0040_0000);
        bus_wr(8'h14, 32'h0040_0000);

        // R6: one-cycle latency on rise and fall (mask holds bit 5)
        @(negedge clk);
        src_in = 32'h0000_0020;
        #1 chk("R6 before edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R6 rise", {31'b0, irq_o}, 32'h1);
        src_in = 32'h0;
        #1 chk("R6 still high", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R6 fall", {31'b0, irq_o}, 32'h0);

        // R1: reset in mid-run clears all state
        src_in = 32'h0000_00FF;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after rst", {31'b0, irq_o}, 32'h0);
        chk("R1 pass after rst", pass_o, 32'h0);
        src_in = 32'h0;
        @(negedge clk);
        addr = 8'h30; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R1 pass mask after rst", rd_data, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule